// File: doc/BRIEF.md
# Grouped Channel Scan Sequencer

This block paces an analog-to-digital converter through a range of input channels. It emits a one-cycle convert strobe together with the channel number that the conversion belongs to. The channel range runs from a first to a last channel. Its length is last minus first plus one, and a last below the first collapses the range to the first channel alone. Internal pacing divides the system clock by a programmable ratio, so each internal sample slot lasts `div_ratio` clock cycles.

In continuous mode the strobes are evenly spaced and the channel walks the range and wraps without pause. In grouped mode a group is the range swept `loops` times back to back. After the last strobe of a group the sequencer holds for the converter's conversion time, then for the group interval, and then starts the next group. This keeps the skew between channels of one group small while the group rate stays slow. With the external clock source selected, each rising edge of `ext_clk` either fires a single conversion (continuous) or launches a whole group (grouped). An edge that arrives while a group is still busy is dropped and recorded on a sticky flag.

Top module: `grp_scan_seq`

## Requirements
- R1: After reset `conv_pulse` and `overrun` are 0 and `chan_idx` is 0.
- R2: With the internal source in continuous mode (`ext_src`=0, `grouped`=0), the first strobe comes D cycles after `run_en` goes high, and later strobes are exactly D cycles apart. D is the effective divisor.
- R3: Strobed channels walk from `first_ch` up to max(`first_ch`,`last_ch`) one per strobe and then wrap to `first_ch`. Scanning starts at `first_ch` after reset.
- R4: A `div_ratio` below 2 (0 or 1) acts as 2, so D = max(`div_ratio`, 2).
- R5: In grouped mode (`grouped`=1) a group is N×L strobes D cycles apart: the range swept L times in a row, where L = `loops` and a value of 0 counts as 1.
- R6: With the internal source in grouped mode, the gap from the last strobe of a group to the first strobe of the next is D + `conv_time` + `gap_time` cycles. The group cycle is therefore D×N×L + `conv_time` + `gap_time`.
- R7: With the external source in continuous mode (`ext_src`=1, `grouped`=0), each rising edge of `ext_clk` gives one strobe, exactly 3 cycles after the edge is driven, on the next channel of the range.
- R8: With the external source in grouped mode, an accepted `ext_clk` rising edge launches one group whose first strobe comes 3 + D cycles after the edge. After the group's last strobe the sequencer is busy for `conv_time` more cycles and then waits for an edge. `gap_time` has no effect in this mode.
- R9: In external grouped mode a rising edge that comes no more than D×N×L + `conv_time` cycles after the last accepted edge is ignored: it launches no strobes and sets `overrun`, which stays 1 until reset. Edges spaced further apart never set it.
- R10: While `run_en` is low no strobe is issued and `ext_clk` edges are ignored without setting `overrun`. When `run_en` returns, the first strobe comes D cycles later on the channel that follows the last one strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Gating enable for the whole scan |
| first_ch | input | CH_W | Lowest channel of the range |
| last_ch | input | CH_W | Highest channel of the range |
| div_ratio | input | DIV_W | Clock cycles per internal sample slot (minimum 2) |
| loops | input | LOOP_W | Range sweeps per group (0 treated as 1) |
| conv_time | input | CNT_W | Cycles of conversion hold after a group |
| gap_time | input | CNT_W | Cycles of group interval (internal source only) |
| grouped | input | 1 | 1 = grouped mode, 0 = continuous mode |
| ext_src | input | 1 | 1 = external clock source, 0 = internal divider |
| ext_clk | input | 1 | Asynchronous external sample clock |
| conv_pulse | output | 1 | One-cycle convert strobe |
| chan_idx | output | CH_W | Channel belonging to the latest strobe |
| overrun | output | 1 | Sticky flag: an external edge came while a group was busy |

## Verification
The hardest condition to reach from the ports is an external edge that lands on the very last busy cycle of a group, because the block only accepts the edge one cycle later. The stimulus drives pairs of external edges exactly 11 and exactly 12 cycles apart, with D=2, N=2, L=2 and a conversion time of 3, which puts them on either side of that limit. A denser train spaced 8 cycles apart then gives a mix of accepted and dropped edges. The bench works out arithmetically which edges are accepted and the exact cycle of every strobe they should produce.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/gcs_pace_timer.sv
// Internal sample-slot divider: one tick every max(div_ratio, MIN_DIV) cycles
// while run is high; the count clears whenever run is low.
module gcs_pace_timer #(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        eff_div = (div_ratio < MIN_V) ? MIN_V : div_ratio;
        tick    = run && (cnt_q >= eff_div - ONE);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the clamp keeps ticks at least two cycles apart
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/gcs_edge_sync.sv
// Synchronises the external clock and flags each rising edge for one cycle.
module gcs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R7: one detected edge per external rising edge
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/gcs_chan_step.sv
// Channel range arithmetic: resolves the current channel and its successor.
module gcs_chan_step #(
    parameter int CH_W = 5
) (
    input  logic [CH_W-1:0] first_ch,
    input  logic [CH_W-1:0] last_ch,
    input  logic [CH_W-1:0] ptr,
    output logic [CH_W-1:0] hi_ch,
    output logic [CH_W-1:0] cur_ch,
    output logic [CH_W-1:0] nxt_ch,
    output logic            at_end
);
    always_comb begin
        hi_ch  = (last_ch < first_ch) ? first_ch : last_ch;
        cur_ch = ((ptr < first_ch) || (ptr > hi_ch)) ? first_ch : ptr;
        at_end = (cur_ch == hi_ch);
        nxt_ch = at_end ? first_ch : cur_ch + CH_W'(1);
    end
endmodule

// File: rtl/grp_scan_seq.sv
module grp_scan_seq
    import gcs_pkg::*;
#(
    parameter int CH_W        = 5,
    parameter int DIV_W       = 16,
    parameter int LOOP_W      = 8,
    parameter int CNT_W       = 16,
    parameter int MIN_DIV     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CH_W-1:0]   first_ch,
    input  logic [CH_W-1:0]   last_ch,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [LOOP_W-1:0] loops,
    input  logic [CNT_W-1:0]  conv_time,
    input  logic [CNT_W-1:0]  gap_time,
    input  logic              grouped,
    input  logic              ext_src,
    input  logic              ext_clk,
    output logic              conv_pulse,
    output logic [CH_W-1:0]   chan_idx,
    output logic              overrun
);
    localparam int W_W = CNT_W + 1;

    typedef struct packed {
        seq_state_e        state;
        logic [W_W-1:0]    wcnt;
        logic [CH_W-1:0]   ptr;
        logic [LOOP_W-1:0] loop;
        logic [CH_W-1:0]   chan;
        logic              pulse;
        logic              ovr;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              tick, rise, timer_run;
    logic [CH_W-1:0]   hi_ch, cur_ch, nxt_ch;
    logic              at_end;
    logic              ext_cont, ext_grp, fire, last_loop;
    logic [LOOP_W-1:0] lps, loop_cur;
    logic [W_W-1:0]    wait_len;
    seq_state_e        ready_state;

    gcs_pace_timer #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_pace (
        .clk(clk), .rst_n(rst_n), .run(timer_run),
        .div_ratio(div_ratio), .tick(tick)
    );

    gcs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(rise)
    );

    gcs_chan_step #(.CH_W(CH_W)) u_step (
        .first_ch(first_ch), .last_ch(last_ch), .ptr(q.ptr),
        .hi_ch(hi_ch), .cur_ch(cur_ch), .nxt_ch(nxt_ch), .at_end(at_end)
    );

    always_comb begin
        ext_cont    = ext_src && !grouped;
        ext_grp     = ext_src && grouped;
        timer_run   = run_en && (q.state == ST_RUN) && !ext_cont;
        fire        = ext_cont ? (run_en && rise) : tick;
        lps         = (loops == '0) ? LOOP_W'(1) : loops;
        loop_cur    = (q.loop >= lps) ? '0 : q.loop;
        last_loop   = (loop_cur == lps - LOOP_W'(1));
        wait_len    = W_W'(conv_time) + (ext_src ? W_W'(0) : W_W'(gap_time));
        ready_state = ext_grp ? ST_IDLE : ST_RUN;

        d       = q;
        d.pulse = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (!ext_grp)             d.state = ST_RUN;
                else if (run_en && rise)  d.state = ST_RUN;
            end
            ST_RUN: begin
            end
            ST_HOLD: begin
                if (run_en) begin
                    if (q.wcnt <= W_W'(1)) d.state = ready_state;
                    else                   d.wcnt  = q.wcnt - W_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (fire) begin
            d.pulse = 1'b1;
            d.chan  = cur_ch;
            d.ptr   = nxt_ch;
            if (at_end) d.loop = last_loop ? '0 : loop_cur + LOOP_W'(1);
            else        d.loop = loop_cur;
            if (grouped && at_end && last_loop) begin
                if (wait_len == '0) begin
                    d.state = ready_state;
                end else begin
                    d.state = ST_HOLD;
                    d.wcnt  = wait_len;
                end
            end
        end

        if (ext_grp && run_en && rise && (q.state != ST_IDLE)) d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, wcnt: '0, ptr: '0, loop: '0,
                   chan: '0, pulse: 1'b0, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign conv_pulse = q.pulse;
    assign chan_idx   = q.chan;
    assign overrun    = q.ovr;

    // R3: every strobed channel lies inside the configured range
    assert_chan_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_pulse && $stable(first_ch) && $stable(last_ch))
        |-> (chan_idx >= first_ch) && (chan_idx <= hi_ch));

    // R6: the post-group hold issues no strobe
    assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HOLD && !ext_cont) |=> !conv_pulse);

    // R8: an idle external-grouped sequencer waits silently for an edge
    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && ext_grp) |=> !conv_pulse);

    // R9: overrun is sticky
    assert_sticky_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R10: no strobe follows a cycle without enable
    assert_gated_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !conv_pulse);
endmodule

// File: tb/grp_scan_seq_test.sv
module grp_scan_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CH_W = 5, DIV_W = 16, LOOP_W = 8, CNT_W = 16;
    localparam int LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0;
    logic [CH_W-1:0] first_ch = '0, last_ch = '0;
    logic [DIV_W-1:0] div_ratio = 16'd2;
    logic [LOOP_W-1:0] loops = 8'd1;
    logic [CNT_W-1:0] conv_time = '0, gap_time = '0;
    logic grouped = 1'b0, ext_src = 1'b0, ext_clk = 1'b0;
    logic conv_pulse, overrun;
    logic [CH_W-1:0] chan_idx;

    int checks = 0, errors = 0, cyc = 0, pc = 0;
    int ptime[64];
    int pch[64];
    int et[16];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    grp_scan_seq uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .first_ch(first_ch),
        .last_ch(last_ch), .div_ratio(div_ratio), .loops(loops),
        .conv_time(conv_time), .gap_time(gap_time), .grouped(grouped),
        .ext_src(ext_src), .ext_clk(ext_clk), .conv_pulse(conv_pulse),
        .chan_idx(chan_idx), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (rst_n && conv_pulse && pc < 64) begin
            ptime[pc] = cyc;
            pch[pc]   = int'(chan_idx);
            pc++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; ext_clk = 1'b0;
        pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int eff_d(input int dv);
        return (dv < 2) ? 2 : dv;
    endfunction

    // Internal-source run: continuous (R2/R3/R4) or grouped (R5/R6)
    task automatic int_run(input int dv, input int f, input int l, input int lp,
                           input int cv, input int gp, input bit grp, input int n);
        int dd, hi, nn, ll, nl, t0, guard;
        do_reset();
        div_ratio = DIV_W'(dv); first_ch = CH_W'(f); last_ch = CH_W'(l);
        loops = LOOP_W'(lp); conv_time = CNT_W'(cv); gap_time = CNT_W'(gp);
        grouped = grp; ext_src = 1'b0;
        @(negedge clk);
        run_en = 1'b1; t0 = cyc;
        guard = 0;
        while (pc < n && guard < 4000) begin @(posedge clk); guard++; end
        @(negedge clk); run_en = 1'b0;
        dd = eff_d(dv); hi = (l < f) ? f : l; nn = hi - f + 1;
        ll = (lp == 0) ? 1 : lp; nl = nn * ll;
        chk(pc >= n, grp ? "R5 strobe count" : "R2 strobe count", pc, n);
        for (int k = 0; k < n && k < pc; k++) begin
            int te, ce;
            if (!grp) begin
                te = t0 + dd * (k + 1);
                ce = f + (k % nn);
                chk(ptime[k] == te, dv < 2 ? "R4 clamped spacing" : "R2 spacing", ptime[k], te);
                chk(pch[k] == ce, "R3 channel order", pch[k], ce);
            end else begin
                te = t0 + dd + (k / nl) * (dd * nl + cv + gp) + (k % nl) * dd;
                ce = f + ((k % nl) % nn);
                chk(ptime[k] == te, "R6 group timing", ptime[k], te);
                chk(pch[k] == ce, "R5 group channel order", pch[k], ce);
            end
        end
    endtask

    task automatic ext_edges(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1; et[i] = cyc;
            @(negedge clk); ext_clk = 1'b0;
            repeat (spacing - 2) @(negedge clk);
        end
        repeat (40) @(negedge clk);
    endtask

    // External grouped: D=2, range 0..1, L=2, conv 3, gap 9 (gap unused)
    task automatic ext_grp_run(input int n, input int spacing);
        int busy, last_acc, k, exp_ovr;
        do_reset();
        div_ratio = 16'd2; first_ch = '0; last_ch = 5'd1; loops = 8'd2;
        conv_time = 16'd3; gap_time = 16'd9; grouped = 1'b1; ext_src = 1'b1;
        @(negedge clk); run_en = 1'b1;
        ext_edges(n, spacing);
        busy = 2 * 4 + 3; last_acc = -1000; k = 0; exp_ovr = 0;
        for (int i = 0; i < n; i++) begin
            if (et[i] - last_acc > busy) begin
                last_acc = et[i];
                for (int p = 0; p < 4; p++) begin
                    int te;
                    te = et[i] + LAT + 2 * (p + 1);
                    if (k < pc) begin
                        chk(ptime[k] == te, "R8 group launch timing", ptime[k], te);
                        chk(pch[k] == p % 2, "R8 group channel", pch[k], p % 2);
                    end
                    k++;
                end
            end else begin
                exp_ovr = 1;
            end
        end
        chk(pc == k, "R9 strobes from accepted edges only", pc, k);
        chk(int'(overrun) == exp_ovr, "R9 overrun flag", int'(overrun), exp_ovr);
        run_en = 1'b0;
    endtask

    initial begin
        int pcs, t1;
        do_reset();
        chk(conv_pulse == 1'b0, "R1 strobe low", int'(conv_pulse), 0);
        chk(overrun == 1'b0, "R1 overrun low", int'(overrun), 0);
        chk(chan_idx == '0, "R1 channel zero", int'(chan_idx), 0);

        // Continuous internal sweep over divisors and ranges
        for (int di = 0; di < 3; di++) begin
            for (int ri = 0; ri < 3; ri++) begin
                int dv, f, l;
                dv = (di == 0) ? 0 : (di == 1) ? 1 : 3;
                f  = (ri == 0) ? 0 : (ri == 1) ? 2 : 6;
                l  = (ri == 0) ? 0 : (ri == 1) ? 5 : 3;
                int_run(dv, f, l, 1, 0, 0, 1'b0, 7);
            end
        end

        // Grouped internal configurations
        int_run(2, 0, 1, 2, 3, 5, 1'b1, 12);
        int_run(3, 4, 6, 1, 0, 0, 1'b1, 9);
        int_run(2, 1, 2, 0, 1, 0, 1'b1, 6);
        int_run(4, 0, 2, 3, 0, 4, 1'b1, 18);

        // R10: pause and resume in continuous internal mode, D=3, range 0..3
        do_reset();
        div_ratio = 16'd3; first_ch = '0; last_ch = 5'd3; grouped = 1'b0; ext_src = 1'b0;
        @(negedge clk); run_en = 1'b1;
        while (pc < 2) @(posedge clk);
        @(negedge clk); run_en = 1'b0; pcs = pc;
        repeat (15) @(negedge clk);
        chk(pc == pcs, "R10 no strobe while disabled", pc, pcs);
        run_en = 1'b1; t1 = cyc;
        repeat (12) @(negedge clk);
        run_en = 1'b0;
        chk(pc > pcs, "R10 resume strobes", pc, pcs + 1);
        if (pc > pcs) begin
            chk(ptime[pcs] == t1 + 3, "R10 resume timing", ptime[pcs], t1 + 3);
            chk(pch[pcs] == pcs % 4, "R10 resume channel", pch[pcs], pcs % 4);
        end

        // R7: external continuous, range 1..3, edges every 5 cycles
        do_reset();
        first_ch = 5'd1; last_ch = 5'd3; grouped = 1'b0; ext_src = 1'b1;
        @(negedge clk); run_en = 1'b1;
        ext_edges(6, 5);
        chk(pc == 6, "R7 one strobe per edge", pc, 6);
        for (int k = 0; k < 6 && k < pc; k++) begin
            chk(ptime[k] == et[k] + LAT, "R7 edge latency", ptime[k], et[k] + LAT);
            chk(pch[k] == 1 + k % 3, "R7 channel order", pch[k], 1 + k % 3);
        end
        chk(overrun == 1'b0, "R7 no overrun in continuous", int'(overrun), 0);

        // R10: external edges ignored while disabled (grouped external)
        do_reset();
        grouped = 1'b1; ext_src = 1'b1; div_ratio = 16'd2; first_ch = '0; last_ch = 5'd1;
        ext_edges(3, 4);
        chk(pc == 0, "R10 edges ignored when disabled", pc, 0);
        chk(overrun == 1'b0, "R10 no overrun when disabled", int'(overrun), 0);

        // R8/R9: boundary and dense edge trains
        ext_grp_run(3, 20);
        ext_grp_run(2, 12);
        ext_grp_run(2, 11);
        ext_grp_run(6, 8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule